// File: doc/BRIEF.md
# Single-Cell Pack Protection Fault Sequencer

This block decides when the charge and discharge FET gate enables of a single-cell battery pack are allowed on. It watches five fault comparator flags that arrive already digitised and synchronous to the clock: short circuit in discharge, overcurrent in discharge, overcurrent in charge, cell overvoltage and cell undervoltage. Each flag has its own qualification timer. The timer counts ticks of a slow enable strobe, nominally 32.768 kHz. A fault trips only when its flag has stayed high without a break for its full delay.

Once a fault trips, the block latches a fault mode and holds both FETs open. The fault mode does not end when the fault flag goes away. Each fault class has its own release condition, built from load-removal, charger-versus-cell and release-level indications. When that condition is met, the block returns to the normal state. Firmware can also force either FET open on its own. Removing such a request never closes a FET that a fault is holding open.

Top module: `batt_guard_seq`

## Requirements
- R1: Out of synchronous reset the block is in the normal state: `fault_code` is 0, and `chg_en` and `dsg_en` are both 1 while no firmware request is set.
- R2: A fault trips on the clock edge where its flag is high together with `tick`, provided this is the N-th tick since the flag last went high, where N is that fault's delay count. If the flag is low on any clock cycle, that fault's count restarts from zero.
- R3: The delay counts are parameters. Their defaults are 11 for short circuit, 1024 for discharge overcurrent, 256 for charge overcurrent, 32768 for overvoltage and 1024 for undervoltage.
- R4: A tripped fault sets exactly one bit of `fault_code`: bit 0 short circuit, bit 1 discharge overcurrent, bit 2 charge overcurrent, bit 3 overvoltage, bit 4 undervoltage. While any bit is set, `chg_en` and `dsg_en` are both 0.
- R5: If several faults qualify on the same edge, the one recorded follows this order of precedence: short circuit, then discharge overcurrent, then charge overcurrent, then overvoltage, then undervoltage.
- R6: A short-circuit or discharge-overcurrent fault is left on the edge after `load_gone` is seen high, and on no other condition.
- R7: A charge-overcurrent fault is left on the edge after `chg_below_cell` is seen high. `load_gone` has no effect on it.
- R8: An overvoltage fault is left only on the edge after `chg_below_cell` and `cell_below_ovrel` are seen high on the same cycle. Either one alone has no effect.
- R9: An undervoltage fault is left on the edge after `cell_above_uvrel` is seen high.
- R10: `fw_open_chg` forces `chg_en` to 0 and `fw_open_dsg` forces `dsg_en` to 0, each on its own. Clearing a request never sets an enable that a fault holds at 0.
- R11: A fault mode persists after its flag drops. While in a fault mode, other fault flags do not change `fault_code`.
- R12: In the normal state all five detectors keep qualifying, even while a firmware request holds a FET open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Delay time-base strobe, one cycle wide |
| scd_flag | input | 1 | Short circuit in discharge comparator output |
| ocd_flag | input | 1 | Discharge overcurrent comparator output |
| occ_flag | input | 1 | Charge overcurrent comparator output |
| ov_flag | input | 1 | Cell above overvoltage trip level |
| uv_flag | input | 1 | Cell below undervoltage trip level |
| load_gone | input | 1 | Load removal detected |
| chg_below_cell | input | 1 | Charger voltage more than 300 mV under the cell |
| cell_below_ovrel | input | 1 | Cell below overvoltage release level (trip minus 215 mV) |
| cell_above_uvrel | input | 1 | Cell above undervoltage release level (trip plus 105 mV) |
| fw_open_chg | input | 1 | Firmware request to open the charge FET |
| fw_open_dsg | input | 1 | Firmware request to open the discharge FET |
| chg_en | output | 1 | Charge FET gate enable |
| dsg_en | output | 1 | Discharge FET gate enable |
| fault_code | output | 5 | One-hot active fault, 0 in the normal state |

## Verification
The bench shortens the delays to 2, 8, 4, 40 and 8 ticks, in the order short circuit, discharge overcurrent, charge overcurrent, overvoltage and undervoltage. With these values every trip point, and the tick just before it, takes only a few dozen cycles. The overvoltage delay is also far longer than all the others. This lets the priority cases have several faults qualify on the same edge, and it also lets a short delay win over a long one even though the long one has higher precedence. The default counts are reached only through elaboration of the block.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

    localparam int NF = 5;

    // bit positions of the fault vector; lower index wins
    localparam int B_SCD = 0;
    localparam int B_OCD = 1;
    localparam int B_OCC = 2;
    localparam int B_OV  = 3;
    localparam int B_UV  = 4;

    typedef logic [NF-1:0] fvec_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRIP = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        fvec_t code;
    } guard_st_t;

    typedef struct packed {
        logic load_gone;
        logic chg_below_cell;
        logic cell_below_ovrel;
        logic cell_above_uvrel;
    } rel_t;

    // keep only the lowest-index set bit
    function automatic fvec_t pick_first(fvec_t q);
        fvec_t res;
        res = '0;
        for (int i = 0; i < NF; i++) begin
            if (q[i] && (res == '0)) res[i] = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/qual_timer.sv
module qual_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tick,
    input  logic flag,
    output logic trip
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign trip = arm && flag && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm || !flag) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/release_eval.sv
module release_eval
    import batt_guard_pkg::*;
(
    input  fvec_t code,
    input  rel_t  rel,
    output logic  release_ok
);
    fvec_t cond;

    always_comb begin
        cond        = '0;
        cond[B_SCD] = rel.load_gone;
        cond[B_OCD] = rel.load_gone;
        cond[B_OCC] = rel.chg_below_cell;
        cond[B_OV]  = rel.chg_below_cell && rel.cell_below_ovrel;
        cond[B_UV]  = rel.cell_above_uvrel;
    end

    assign release_ok = |(code & cond);
endmodule

// File: rtl/fet_gate.sv
module fet_gate
    import batt_guard_pkg::*;
(
    input  mode_e mode,
    input  logic  fw_open_chg,
    input  logic  fw_open_dsg,
    output logic  chg_en,
    output logic  dsg_en
);
    logic run_ok;

    assign run_ok = (mode == ST_RUN);
    assign chg_en = run_ok && !fw_open_chg;
    assign dsg_en = run_ok && !fw_open_dsg;
endmodule

// File: rtl/batt_guard_seq.sv
module batt_guard_seq
    import batt_guard_pkg::*;
#(
    parameter int unsigned T_SCD = 11,
    parameter int unsigned T_OCD = 1024,
    parameter int unsigned T_OCC = 256,
    parameter int unsigned T_OV  = 32768,
    parameter int unsigned T_UV  = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       scd_flag,
    input  logic       ocd_flag,
    input  logic       occ_flag,
    input  logic       ov_flag,
    input  logic       uv_flag,
    input  logic       load_gone,
    input  logic       chg_below_cell,
    input  logic       cell_below_ovrel,
    input  logic       cell_above_uvrel,
    input  logic       fw_open_chg,
    input  logic       fw_open_dsg,
    output logic       chg_en,
    output logic       dsg_en,
    output logic [4:0] fault_code
);
    localparam int unsigned LIMS [NF] = '{T_SCD, T_OCD, T_OCC, T_OV, T_UV};

    guard_st_t st_q, st_d;
    fvec_t     raw, trip;
    rel_t      rel;
    logic      arm, release_ok;

    assign raw = {uv_flag, ov_flag, occ_flag, ocd_flag, scd_flag};
    assign arm = (st_q.mode == ST_RUN);
    assign rel = '{load_gone:        load_gone,
                   chg_below_cell:   chg_below_cell,
                   cell_below_ovrel: cell_below_ovrel,
                   cell_above_uvrel: cell_above_uvrel};

    for (genvar g = 0; g < NF; g++) begin : g_qual
        qual_timer #(.LIMIT(LIMS[g])) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .arm  (arm),
            .tick (tick),
            .flag (raw[g]),
            .trip (trip[g])
        );
    end

    release_eval u_rel (
        .code       (st_q.code),
        .rel        (rel),
        .release_ok (release_ok)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            ST_RUN: begin
                if (|trip) begin
                    st_d.mode = ST_TRIP;
                    st_d.code = pick_first(trip);
                end
            end
            ST_TRIP: begin
                if (release_ok) begin
                    st_d.mode = ST_RUN;
                    st_d.code = '0;
                end
            end
            default: st_d = '{mode: ST_RUN, code: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: ST_RUN, code: '0};
        else     st_q <= st_d;
    end

    fet_gate u_gate (
        .mode        (st_q.mode),
        .fw_open_chg (fw_open_chg),
        .fw_open_dsg (fw_open_dsg),
        .chg_en      (chg_en),
        .dsg_en      (dsg_en)
    );

    assign fault_code = st_q.code;
endmodule

// File: rtl/guard_props.sv
module guard_props (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       load_gone,
    input logic       chg_below_cell,
    input logic       cell_below_ovrel,
    input logic       cell_above_uvrel,
    input logic       fw_open_chg,
    input logic       fw_open_dsg,
    input logic       chg_en,
    input logic       dsg_en,
    input logic [4:0] fault_code
);
    a_r4_onehot_code: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault_code));

    a_r4_fault_opens_both: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 5'd0) |-> (!chg_en && !dsg_en));

    a_r10_fw_chg_open: assert property (@(posedge clk) disable iff (rst)
        fw_open_chg |-> !chg_en);

    a_r10_fw_dsg_open: assert property (@(posedge clk) disable iff (rst)
        fw_open_dsg |-> !dsg_en);

    // R2: entering a fault needs a tick on the deciding edge
    a_r2_trip_on_tick: assert property (@(posedge clk) disable iff (rst)
        ((fault_code != 5'd0) && $past(fault_code == 5'd0) && !$past(rst)) |-> $past(tick));

    a_r6_dis_release: assert property (@(posedge clk) disable iff (rst)
        ((fault_code == 5'd0) && $past(fault_code[0] || fault_code[1]) && !$past(rst))
        |-> $past(load_gone));

    a_r7_occ_release: assert property (@(posedge clk) disable iff (rst)
        ((fault_code == 5'd0) && $past(fault_code[2]) && !$past(rst))
        |-> $past(chg_below_cell));

    a_r8_ov_release: assert property (@(posedge clk) disable iff (rst)
        ((fault_code == 5'd0) && $past(fault_code[3]) && !$past(rst))
        |-> $past(chg_below_cell && cell_below_ovrel));

    a_r9_uv_release: assert property (@(posedge clk) disable iff (rst)
        ((fault_code == 5'd0) && $past(fault_code[4]) && !$past(rst))
        |-> $past(cell_above_uvrel));

    // R11: a fault code never switches straight to another fault
    a_r11_no_swap: assert property (@(posedge clk) disable iff (rst)
        (($past(fault_code) != 5'd0) && (fault_code != 5'd0) && !$past(rst))
        |-> $stable(fault_code));
endmodule

bind batt_guard_seq guard_props u_guard_props (
    .clk              (clk),
    .rst              (rst),
    .tick             (tick),
    .load_gone        (load_gone),
    .chg_below_cell   (chg_below_cell),
    .cell_below_ovrel (cell_below_ovrel),
    .cell_above_uvrel (cell_above_uvrel),
    .fw_open_chg      (fw_open_chg),
    .fw_open_dsg      (fw_open_dsg),
    .chg_en           (chg_en),
    .dsg_en           (dsg_en),
    .fault_code       (fault_code)
);

// File: tb/test_batt_guard_seq.sv
`timescale 1ns/1ps
module test_batt_guard_seq;

    logic clk = 1'b0;
    logic rst, tick;
    logic scd_flag, ocd_flag, occ_flag, ov_flag, uv_flag;
    logic load_gone, chg_below_cell, cell_below_ovrel, cell_above_uvrel;
    logic fw_open_chg, fw_open_dsg;
    logic chg_en, dsg_en;
    logic [4:0] fault_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    batt_guard_seq #(
        .T_SCD(2), .T_OCD(8), .T_OCC(4), .T_OV(40), .T_UV(8)
    ) i_batt_guard_seq (
        .clk(clk), .rst(rst), .tick(tick),
        .scd_flag(scd_flag), .ocd_flag(ocd_flag), .occ_flag(occ_flag),
        .ov_flag(ov_flag), .uv_flag(uv_flag),
        .load_gone(load_gone), .chg_below_cell(chg_below_cell),
        .cell_below_ovrel(cell_below_ovrel), .cell_above_uvrel(cell_above_uvrel),
        .fw_open_chg(fw_open_chg), .fw_open_dsg(fw_open_dsg),
        .chg_en(chg_en), .dsg_en(dsg_en), .fault_code(fault_code)
    );

    // {flags uv,ov,occ,ocd,scd}, tick count, expected code
    localparam logic [17:0] VEC [12] = '{
        {5'b00001, 8'd2,  5'b00001},  // R2 scd at limit
        {5'b00001, 8'd1,  5'b00000},  // R2 scd one short
        {5'b00010, 8'd8,  5'b00010},  // R3 ocd
        {5'b00010, 8'd7,  5'b00000},
        {5'b00100, 8'd4,  5'b00100},  // R3 occ
        {5'b01000, 8'd40, 5'b01000},  // R3 ov
        {5'b01000, 8'd39, 5'b00000},
        {5'b10000, 8'd8,  5'b10000},  // R3 uv
        {5'b11111, 8'd2,  5'b00001},  // R5 all flags
        {5'b11110, 8'd4,  5'b00100},  // R5 occ first in time
        {5'b10010, 8'd8,  5'b00010},  // R5 ocd over uv, same edge
        {5'b11000, 8'd8,  5'b10000}   // R5 uv before ov
    };

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; cyc();
            tick = 1'b0; cyc();
        end
    endtask

    task automatic set_flags(logic [4:0] f);
        {uv_flag, ov_flag, occ_flag, ocd_flag, scd_flag} = f;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0;
        set_flags(5'b0);
        load_gone = 0; chg_below_cell = 0; cell_below_ovrel = 0; cell_above_uvrel = 0;
        fw_open_chg = 0; fw_open_dsg = 0;
        cyc(2);
        rst = 1'b0;
        cyc();
    endtask

    task automatic check(string req, logic [4:0] ec, logic ech, logic eds);
        checks++;
        if (fault_code !== ec || chg_en !== ech || dsg_en !== eds) begin
            failures++;
            $display("FAIL %s: code=%b chg=%b dsg=%b expected code=%b chg=%b dsg=%b",
                     req, fault_code, chg_en, dsg_en, ec, ech, eds);
        end
    endtask

    initial begin
        rst = 1'b1;
        do_reset();
        check("R1 reset state", 5'b0, 1, 1);

        for (int i = 0; i < 12; i++) begin
            logic [4:0] ec;
            do_reset();
            set_flags(VEC[i][17:13]);
            ticks(int'(VEC[i][12:5]));
            ec = VEC[i][4:0];
            check($sformatf("R4 vector %0d", i), ec, ec == 0, ec == 0);
        end

        // R2 restart after a one-cycle drop
        do_reset();
        ocd_flag = 1; ticks(7);
        ocd_flag = 0; cyc();
        ocd_flag = 1; ticks(7);
        check("R2 drop restarts count", 5'b0, 1, 1);
        ticks(1);
        check("R2 trip after restart", 5'b00010, 0, 0);

        // R6/R11 short circuit held, other releases ignored
        do_reset();
        scd_flag = 1; ticks(2);
        scd_flag = 0; cyc(3);
        check("R11 fault holds after flag drop", 5'b00001, 0, 0);
        chg_below_cell = 1; cell_above_uvrel = 1; cell_below_ovrel = 1; cyc(2);
        check("R6 scd ignores other releases", 5'b00001, 0, 0);
        chg_below_cell = 0; cell_above_uvrel = 0; cell_below_ovrel = 0;
        load_gone = 1; cyc();
        check("R6 scd cleared by load_gone", 5'b0, 1, 1);
        load_gone = 0;

        // R6 discharge overcurrent release
        do_reset();
        ocd_flag = 1; ticks(8); ocd_flag = 0;
        load_gone = 1; cyc();
        check("R6 ocd cleared by load_gone", 5'b0, 1, 1);
        load_gone = 0;

        // R7 and R11: other flags do not change code in fault
        do_reset();
        occ_flag = 1; ticks(4); occ_flag = 0;
        scd_flag = 1; ticks(3); scd_flag = 0;
        check("R11 scd ignored during occ fault", 5'b00100, 0, 0);
        load_gone = 1; cyc(2);
        check("R7 load_gone ignored for occ", 5'b00100, 0, 0);
        load_gone = 0; chg_below_cell = 1; cyc();
        check("R7 occ cleared by chg_below_cell", 5'b0, 1, 1);
        chg_below_cell = 0;

        // R8 overvoltage needs both conditions
        do_reset();
        ov_flag = 1; ticks(40); ov_flag = 0;
        chg_below_cell = 1; cyc(2);
        check("R8 chg_below_cell alone", 5'b01000, 0, 0);
        chg_below_cell = 0; cell_below_ovrel = 1; cyc(2);
        check("R8 cell_below_ovrel alone", 5'b01000, 0, 0);
        chg_below_cell = 1; cyc();
        check("R8 both release ov", 5'b0, 1, 1);
        chg_below_cell = 0; cell_below_ovrel = 0;

        // R9 undervoltage release
        do_reset();
        uv_flag = 1; ticks(8); uv_flag = 0;
        load_gone = 1; cyc(2);
        check("R9 load_gone ignored for uv", 5'b10000, 0, 0);
        load_gone = 0; cell_above_uvrel = 1; cyc();
        check("R9 uv cleared", 5'b0, 1, 1);
        cell_above_uvrel = 0;

        // R10 firmware overrides
        do_reset();
        fw_open_chg = 1; cyc();
        check("R10 open chg only", 5'b0, 0, 1);
        fw_open_chg = 0; fw_open_dsg = 1; cyc();
        check("R10 open dsg only", 5'b0, 1, 0);
        // R12 detector still active under override
        occ_flag = 1; ticks(4); occ_flag = 0;
        check("R12 trip with override set", 5'b00100, 0, 0);
        fw_open_dsg = 0; cyc(2);
        check("R10 clear override keeps FETs open", 5'b00100, 0, 0);
        chg_below_cell = 1; cyc();
        check("R10 enables return after release", 5'b0, 1, 1);
        chg_below_cell = 0;

        // R3 recount after release
        occ_flag = 1; ticks(3);
        check("R3 occ count restarts after release", 5'b0, 1, 1);
        ticks(1);
        check("R3 occ trips again", 5'b00100, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule